// File: doc/BRIEF.md
# I2C Byte Transfer Engine

This block moves exactly one byte across an I2C bus for each request from a sequencer one level up. A request carries a four-flag command. The flags can be combined freely, so one request can open a transaction with a start condition, move one byte in either direction, and close with a stop condition. A sequencer builds a full transaction by issuing several requests in a row. For example, it can send an address byte with a start, then a register byte, then a read byte with a repeated start, and finally a read byte with a stop.

The bit clock is derived by dividing the system clock by a parameter. SDA is changed only at the middle of the SCL low phase, and it is sampled at the middle of the SCL high phase. When a write byte ends, the engine records the acknowledge bit returned by the slave. When a read byte ends, the engine sends its own acknowledge bit. This bit is a NACK if the same request also asked for a stop, and an ACK if it did not. The engine raises a one-cycle completion pulse after every byte.

Top module: `i2c_byte_engine`

## Requirements
- R1: While reset is active, and in the cycle after it is released, `scl` and `sda_o` are 1 and `sda_oe` and `done` are 0.
- R2: The command bits are `cmd[3]`=START, `cmd[2]`=STOP, `cmd[1]`=WRITE and `cmd[0]`=READ. A request is accepted when the engine is idle and WRITE or READ is set. A request with neither of those bits set is ignored: SCL, `sda_oe` and `done` do not change. When WRITE and READ are both set, the byte is written.
- R3: A request that arrives while a byte is in progress is ignored. The byte in progress keeps the command and data that were latched when it was accepted, and no extra byte follows it.
- R4: One SCL period is `PERIOD_CLKS` clocks, measured from one rising edge to the next. While the engine is idle, SCL holds its level. It rests low after a byte that has no STOP.
- R5: When START is set, SDA falls exactly once while SCL is high and SDA is driven. When START is clear, SDA never falls in that way.
- R6: A write sends `wr_data` MSB first with `sda_oe` high. A driven SDA never changes while SCL stays high within a data or acknowledge bit.
- R7: During the acknowledge bit after a write, `sda_oe` is low. The value of `sda_i` sampled in that bit appears on `slv_nack` once `done` has pulsed.
- R8: A read samples `sda_i` once per bit, MSB first, with `sda_oe` low. The assembled byte is on `rd_data` when `done` pulses.
- R9: After a read, the engine drives an acknowledge bit. The bit is 1 (NACK) when STOP is set and 0 (ACK) when STOP is clear.
- R10: When STOP is set, SDA rises exactly once while SCL is high, after the acknowledge bit. The engine then rests with `scl`=1, `sda_o`=1 and `sda_oe`=0. Whenever the engine is idle, `sda_o` is 1 and `sda_oe` is 0.
- R11: `done` is a single-cycle pulse. It is first high `PERIOD_CLKS*N+1` clocks after the accepting edge, where N is 10 with START and 9 without.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Byte request, sampled while idle |
| cmd | input | 4 | Command flags: START, STOP, WRITE, READ |
| wr_data | input | BYTE_W | Byte to send on a write |
| done | output | 1 | One-cycle pulse after each acknowledge bit |
| rd_data | output | BYTE_W | Byte received by the last read |
| slv_nack | output | 1 | Acknowledge level sampled from the slave after a write |
| sda_i | input | 1 | SDA level seen on the bus |
| scl | output | 1 | Bus clock |
| sda_o | output | 1 | SDA value to drive |
| sda_oe | output | 1 | SDA drive enable |

## Verification
The checker assumes that `req` only needs to be honoured while the engine is idle. It treats `sda_i` as meaningful only in read and acknowledge bits. It also assumes no other master disturbs SCL. The stimulus drives `sda_i` from a slave model that changes its bit only on an SCL rising edge. Every sample therefore falls half a phase away from any change. Requests arriving during a busy byte are injected on purpose, so the assumption that they are dropped is exercised rather than avoided.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_WRITE = 3'd2,
      ST_RACK  = 3'd3,
      ST_READ  = 3'd4,
      ST_SACK  = 3'd5,
      ST_STOP  = 3'd6
   } eng_state_e;

   localparam int CMD_W   = 4;
   localparam int F_READ  = 0;
   localparam int F_WRITE = 1;
   localparam int F_STOP  = 2;
   localparam int F_START = 3;
endpackage

// File: rtl/i2c_eng_timer.sv
module i2c_eng_timer #(
   parameter int PERIOD_CLKS = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic launch,
   input  logic hold_high,
   output logic scl,
   output logic mid_low,
   output logic mid_high,
   output logic period_end
);
   localparam int CNT_W = $clog2(PERIOD_CLKS);
   localparam int HALF  = PERIOD_CLKS / 2;
   localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(PERIOD_CLKS - 1);
   localparam logic [CNT_W-1:0] RISE_C  = CNT_W'(HALF - 1);
   localparam logic [CNT_W-1:0] MIDLO_C = CNT_W'(HALF / 2);
   localparam logic [CNT_W-1:0] MIDHI_C = CNT_W'(HALF + HALF / 2);

   generate
      if (PERIOD_CLKS < 8 || (PERIOD_CLKS % 2) != 0) begin : g_bad_period
         $error("PERIOD_CLKS must be even and at least 8");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || cnt_q == LAST_C) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign period_end = run && (cnt_q == LAST_C);
   assign mid_low    = run && (cnt_q == MIDLO_C);
   assign mid_high   = run && (cnt_q == MIDHI_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl <= 1'b1;
      end else if (launch) begin
         scl <= 1'b0;
      end else if (run && cnt_q == RISE_C) begin
         scl <= 1'b1;
      end else if (period_end && !hold_high) begin
         scl <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_eng_bitcnt.sv
module i2c_eng_bitcnt #(
   parameter int BYTE_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic multi,
   output logic seg_end
);
   localparam int IDX_W = $clog2(BYTE_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("BYTE_W must be at least 2");
      end
   endgenerate

   logic [IDX_W-1:0] idx_q;

   assign seg_end = step && (idx_q == (multi ? LAST_IDX : '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (seg_end) begin
         idx_q <= '0;
      end else if (step) begin
         idx_q <= idx_q + 1'b1;
      end
   end
endmodule

// File: rtl/i2c_eng_shift.sv
module i2c_eng_shift #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_data,
   input  logic              tx_adv,
   output logic              tx_bit,
   input  logic              rx_adv,
   input  logic              rx_in,
   output logic [BYTE_W-1:0] rx_data
);
   logic [BYTE_W-1:0] tx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
      end else if (load) begin
         tx_q <= load_data;
      end else if (tx_adv) begin
         tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
      end
   end

   assign tx_bit = tx_q[BYTE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
      end else if (rx_adv) begin
         rx_data <= {rx_data[BYTE_W-2:0], rx_in};
      end
   end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
   import i2c_eng_pkg::*;
#(
   parameter int PERIOD_CLKS = 250,
   parameter int BYTE_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [CMD_W-1:0]  cmd,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              done,
   output logic [BYTE_W-1:0] rd_data,
   output logic              slv_nack,
   input  logic              sda_i,
   output logic              scl,
   output logic              sda_o,
   output logic              sda_oe
);
   eng_state_e        st_q, st_d;
   logic [CMD_W-1:0]  cmd_q;
   logic              accept;
   logic              mid_low, mid_high, period_end, seg_end;
   logic              tx_bit;

   assign accept = (st_q == ST_IDLE) && req && (cmd[F_WRITE] || cmd[F_READ]);

   i2c_eng_timer #(.PERIOD_CLKS(PERIOD_CLKS)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (st_q != ST_IDLE),
      .launch     (accept),
      .hold_high  (st_q == ST_STOP),
      .scl        (scl),
      .mid_low    (mid_low),
      .mid_high   (mid_high),
      .period_end (period_end)
   );

   i2c_eng_bitcnt #(.BYTE_W(BYTE_W)) u_bits (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (period_end),
      .multi   (st_q == ST_WRITE || st_q == ST_READ),
      .seg_end (seg_end)
   );

   i2c_eng_shift #(.BYTE_W(BYTE_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_data (wr_data),
      .tx_adv    (st_q == ST_WRITE && mid_low),
      .tx_bit    (tx_bit),
      .rx_adv    (st_q == ST_READ && mid_high),
      .rx_in     (sda_i),
      .rx_data   (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (accept) begin
         cmd_q <= cmd;
      end
   end

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:
            if (accept) begin
               if (cmd[F_START])      st_d = ST_START;
               else if (cmd[F_WRITE]) st_d = ST_WRITE;
               else                   st_d = ST_READ;
            end
         ST_START:
            if (seg_end) st_d = cmd_q[F_WRITE] ? ST_WRITE : ST_READ;
         ST_WRITE:
            if (seg_end) st_d = ST_RACK;
         ST_READ:
            if (seg_end) st_d = ST_SACK;
         ST_RACK, ST_SACK:
            if (seg_end) st_d = cmd_q[F_STOP] ? ST_STOP : ST_IDLE;
         ST_STOP:
            if (seg_end) st_d = ST_IDLE;
         default:
            st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_o <= 1'b1;
      end else if (seg_end && st_d == ST_IDLE) begin
         sda_o <= 1'b1;
      end else begin
         case (st_q)
            ST_START: begin
               if (mid_low)       sda_o <= 1'b1;
               else if (mid_high) sda_o <= 1'b0;
            end
            ST_WRITE:
               if (mid_low) sda_o <= tx_bit;
            ST_SACK:
               if (mid_low) sda_o <= cmd_q[F_STOP];
            ST_STOP: begin
               if (mid_low)       sda_o <= 1'b0;
               else if (mid_high) sda_o <= 1'b1;
            end
            default:
               if (mid_low) sda_o <= 1'b1;
         endcase
      end
   end

   always_comb begin
      case (st_q)
         ST_START, ST_WRITE, ST_SACK, ST_STOP: sda_oe = 1'b1;
         default:                              sda_oe = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slv_nack <= 1'b0;
      end else if (st_q == ST_RACK && mid_high) begin
         slv_nack <= sda_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done <= 1'b0;
      else        done <= seg_end && (st_q == ST_RACK || st_q == ST_SACK);
   end
endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk
   import i2c_eng_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             req,
   input logic             done,
   input logic             scl,
   input logic             sda_o,
   input logic             sda_oe,
   input eng_state_e       st,
   input logic [CMD_W-1:0] cmd_q
);
   // R2: the engine only leaves idle in answer to a request
   a_r2_leave_idle_on_req: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == ST_IDLE && st != ST_IDLE) |-> $past(req));

   // R3: the latched command does not move while a byte runs
   a_r3_cmd_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(cmd_q));

   // R4: no SCL activity while resting
   a_r4_scl_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && $past(st) == ST_IDLE) |-> $stable(scl));

   // R6: driven data and acknowledge bits hold while SCL is high
   a_r6_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      (scl && $past(scl) && (st == ST_WRITE || st == ST_SACK) && $past(st) == st)
      |-> $stable(sda_o));

   // R10: bus released with SDA high whenever idle
   a_r10_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> (sda_o && !sda_oe));

   // R11: completion is one cycle wide
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11: completion follows an acknowledge bit
   a_r11_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(st) == ST_RACK || $past(st) == ST_SACK));
endmodule

bind i2c_byte_engine i2c_byte_engine_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .req    (req),
   .done   (done),
   .scl    (scl),
   .sda_o  (sda_o),
   .sda_oe (sda_oe),
   .st     (st_q),
   .cmd_q  (cmd_q)
);

// File: tb/i2c_byte_engine_tb.sv
module i2c_byte_engine_tb;
   localparam int PER = 250;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0;
   logic [3:0] cmd = 4'h0;
   logic [7:0] wr_data = 8'h00;
   logic       sda_i = 1'b1;
   logic       done, slv_nack, scl, sda_o, sda_oe;
   logic [7:0] rd_data;

   int tests = 0;
   int fails = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   i2c_byte_engine #(.PERIOD_CLKS(PER), .BYTE_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .cmd(cmd), .wr_data(wr_data),
      .done(done), .rd_data(rd_data), .slv_nack(slv_nack), .sda_i(sda_i),
      .scl(scl), .sda_o(sda_o), .sda_oe(sda_oe)
   );

   // fields: cmd[20:17] wdata[16:9] slave byte[8:1] slave ack[0]
   // cmd bits: 8=START 4=STOP 2=WRITE 1=READ
   localparam logic [20:0] VECS [6] = '{
      {4'hA, 8'hA6, 8'h00, 1'b0},
      {4'h6, 8'h3C, 8'h00, 1'b1},
      {4'hD, 8'h00, 8'h5A, 1'b0},
      {4'h9, 8'h00, 8'hC3, 1'b0},
      {4'h5, 8'h00, 8'h96, 1'b0},
      {4'hF, 8'h81, 8'h00, 1'b0}
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 180000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, 180000);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic run_byte(input logic [3:0] c, input logic [7:0] wd,
                           input logic [7:0] rb, input logic ak, input bit inject);
      int k = 0, j = 0, r0 = 0, r1 = 0, kd = 0, pulses = 0;
      int starts = 0, stops = 0, tail = 0, d = 0, off, n;
      logic [7:0] got = 8'h00;
      logic [7:0] rdq = 8'h00;
      logic sackb = 1'b0;
      logic pscl, poe, psda;
      bit wmode;
      wmode = c[1];
      off = c[3] ? 1 : 0;
      n = off + 9;
      @(negedge clk);
      req = 1'b1; cmd = c; wr_data = wd;
      pscl = scl; poe = sda_oe; psda = sda_o;
      while (k < 4000) begin
         @(negedge clk);
         k++;
         if (k == 1) req = 1'b0;
         if (inject && k == 1000) begin req = 1'b1; cmd = 4'hD; wr_data = ~wd; end
         if (inject && k == 1001) req = 1'b0;
         if (scl && pscl && sda_oe && poe) begin
            if (psda && !sda_o) starts++;
            if (!psda && sda_o) stops++;
         end
         if (scl && !pscl) begin
            if (j == 0) r0 = k;
            if (j == 1) r1 = k;
            d = j - off;
            sda_i = 1'b1;
            if (d >= 0 && d < 8) begin
               if (wmode) got[7-d] = sda_o && sda_oe;
               else       sda_i = rb[7-d];
            end else if (d == 8) begin
               if (wmode) sda_i = ak;
               else       sackb = sda_o;
            end
            j++;
         end
         if (done) begin
            pulses++;
            if (kd == 0) begin kd = k; rdq = rd_data; end
         end
         if (kd != 0) begin
            tail++;
            if (tail >= (c[2] ? 300 : 20)) break;
         end
         pscl = scl; poe = sda_oe; psda = sda_o;
      end
      sda_i = 1'b1;
      check(kd == PER*n+1, "R11 done latency", kd, PER*n+1);
      check(pulses == 1, "R11 done width", pulses, 1);
      check(r1 - r0 == PER, "R4 scl period", r1 - r0, PER);
      check(starts == off, "R5 start count", starts, off);
      check(stops == (c[2] ? 1 : 0), "R10 stop count", stops, c[2] ? 1 : 0);
      if (wmode) begin
         // R2: with both WRITE and READ set the byte is written
         check(got == wd, "R6 written bits", got, wd);
         check(slv_nack == ak, "R7 slave ack", slv_nack, ak);
      end else begin
         check(rdq == rb, "R8 read byte", rdq, rb);
         check(sackb == c[2], "R9 master ack", sackb, c[2]);
      end
      if (c[2]) check(scl && sda_o && !sda_oe, "R10 rest lines", {scl, sda_o, sda_oe}, 3'b110);
      else      check(!scl && !sda_oe, "R4 scl held low", {scl, sda_oe}, 2'b00);
   endtask

   task automatic quiet_window(input string tag, input int len);
      int chg = 0;
      logic s0;
      s0 = scl;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (scl != s0 || sda_oe || done) chg++;
      end
      check(chg == 0, tag, chg, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(scl && sda_o && !sda_oe && !done, "R1 in reset", {scl, sda_o, sda_oe, done}, 4'b1100);
      rst_n = 1'b1;
      @(negedge clk);
      check(scl && sda_o && !sda_oe && !done, "R1 after release", {scl, sda_o, sda_oe, done}, 4'b1100);

      for (int i = 0; i < 6; i++) begin
         run_byte(VECS[i][20:17], VECS[i][16:9], VECS[i][8:1], VECS[i][0], 1'b0);
      end

      // R2: requests carrying neither WRITE nor READ are dropped
      @(negedge clk); req = 1'b1; cmd = 4'h4;
      @(negedge clk); req = 1'b1; cmd = 4'h8;
      @(negedge clk); req = 1'b0;
      quiet_window("R2 no-data request ignored", 600);

      // R3: a request during a busy byte is dropped
      run_byte(4'h6, 8'h4B, 8'h00, 1'b0, 1'b1);
      quiet_window("R3 no extra byte", 600);

      // R1: reset in mid-transfer restores the rest state
      @(negedge clk); req = 1'b1; cmd = 4'hA; wr_data = 8'h55;
      @(negedge clk); req = 1'b0;
      repeat (700) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(scl && sda_o && !sda_oe && !done, "R1 mid-transfer reset", {scl, sda_o, sda_oe, done}, 4'b1100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule